// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the byte registers of a small 8-bit processor: an accumulator, a flag byte and six general registers that pair up as BC, DE and HL. Each of these eight has a shadow twin, and there is also a 16-bit stack pointer. The block takes one opcode byte, with an optional 16-bit operand, on a valid/ready input. It carries out the opcodes that only move data between registers: byte copies, immediate loads, 16-bit pair steps, loading the stack pointer from HL, and three exchange forms. For every other opcode it raises a one-cycle status pulse.

The exchanges are what set this block apart. The accumulator/flag pair swaps with its shadow pair on its own. The three general pairs swap with their shadows together in one step. DE and HL can also trade places inside the active bank. Opcodes that reach memory through HL or an absolute address are not executed here. They are only reported, so the surrounding sequencer can handle them. Arithmetic and logic operations belong to a separate unit.

`op_ready` is high in every cycle in which reset is low. No back-pressure is ever applied beyond reset. An opcode is consumed on a rising edge at which `op_valid` and `op_ready` are both high. While `op_valid` is low, the opcode and operand inputs are ignored. Register contents are read through a combinational byte port and a stack-pointer output.

Top module: `regfile_core`

## Requirements
- R1: A synchronous reset clears all eight active registers, all eight shadow registers, the stack pointer and the three status pulses to zero, and holds `op_ready` low.
- R2: An opcode takes effect only on a rising edge with both `op_valid` and `op_ready` high; with `op_valid` low no register changes and no pulse is raised, whatever `op_code` and `op_imm` carry.
- R3: Opcodes 0x40 to 0x7F copy the register named by bits 2:0 into the register named by bits 5:3, using the codes B=0, C=1, D=2, E=3, H=4, L=5, A=7; `rd_idx` uses the same codes, and code 6 reads the flag byte.
- R4: Opcode 0x76 changes no register and raises `halt_o` for one cycle.
- R5: The memory forms raise `mem_op_o` for one cycle and change no register. They are every opcode in 0x40 to 0x7F other than 0x76 that has code 6 in either field, plus 0x36, 0x02, 0x0A, 0x12, 0x1A, 0x22, 0x2A, 0x32 and 0x3A.
- R6: An opcode of the form 00ddd110 with ddd not 6 loads `op_imm[7:0]` into the register with code ddd.
- R7: An opcode of the form 00pp0001 loads `op_imm` into the pair pp (0=BC, 1=DE, 2=HL, 3=SP). For BC, DE and HL, bits 15:8 go to B, D or H.
- R8: 00pp0011 adds one to pair pp and 00pp1011 subtracts one, with the same pair codes, wrapping modulo 65536 without touching the flag byte.
- R9: Opcode 0xF9 copies the HL pair into the stack pointer.
- R10: Opcode 0x08 exchanges A and F with their shadow copies and leaves B to L in both banks unchanged.
- R11: Opcode 0xD9 exchanges B, C, D, E, H and L with their shadow copies in one step and leaves A and F in both banks unchanged.
- R12: Opcode 0xEB exchanges DE with HL in the active bank and leaves the shadow bank unchanged.
- R13: Every opcode not covered by R3 to R12 raises `bad_op_o` for one cycle and changes no register.
- R14: Each status pulse is high for exactly the cycle after the accepting edge, and at most one of the three is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode and operand are presented |
| op_ready | output | 1 | Block accepts an opcode this cycle (high outside reset) |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 16 | Immediate operand; the low byte serves 8-bit loads |
| rd_idx | input | 3 | Register code for the read port |
| rd_byte | output | 8 | Active-bank register selected by `rd_idx` |
| sp_o | output | 16 | Stack pointer |
| halt_o | output | 1 | One-cycle pulse for the halt opcode |
| mem_op_o | output | 1 | One-cycle pulse for a memory form |
| bad_op_o | output | 1 | One-cycle pulse for an unhandled opcode |

## Verification
Every register update and every status pulse appears after the single rising edge that accepts the opcode. The bench therefore presents each opcode at a falling edge and checks pulses, all eight bytes and the stack pointer at the next falling edge. The read port is combinational, so the eight bytes are walked through `rd_idx` within that half cycle, before the next edge. At the falling edge of the following opcode, the bench confirms that the previous pulse has dropped. Shadow contents cannot be read directly. They are checked through the byte values that the later exchange opcodes bring into view.

// File: rtl/regfile_pkg.sv
`timescale 1ns/1ps
package regfile_pkg;
  localparam int OPC_W  = 8;
  localparam int NREG   = 8;
  localparam int CODE_W = $clog2(NREG);

  // register codes shared by the move field decode and the read port
  localparam logic [CODE_W-1:0] IDX_B = 3'd0;
  localparam logic [CODE_W-1:0] IDX_D = 3'd2;
  localparam logic [CODE_W-1:0] IDX_E = 3'd3;
  localparam logic [CODE_W-1:0] IDX_H = 3'd4;
  localparam logic [CODE_W-1:0] IDX_L = 3'd5;
  localparam logic [CODE_W-1:0] IDX_F = 3'd6;
  localparam logic [CODE_W-1:0] IDX_A = 3'd7;
  localparam logic [1:0]        PAIR_SP = 2'd3;

  typedef enum logic [3:0] {
    K_BAD,
    K_MOVE,
    K_IMM8,
    K_IMM16,
    K_STEP,
    K_SPHL,
    K_SWAP_AF,
    K_SWAP_ALL,
    K_SWAP_DEHL,
    K_HALT,
    K_MEM
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [CODE_W-1:0] dst;
    logic [CODE_W-1:0] src;
    logic [1:0]        pair;
    logic              down;
  } dec_t;
endpackage

// File: rtl/regfile_dec.sv
`timescale 1ns/1ps
module regfile_dec
  import regfile_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dcd
);
  always_comb begin
    dcd.kind = K_BAD;
    dcd.dst  = opc[5:3];
    dcd.src  = opc[2:0];
    dcd.pair = opc[5:4];
    dcd.down = opc[3];
    unique case (opc[7:6])
      2'b01: begin
        if (opc == 8'h76)                               dcd.kind = K_HALT;  // R4
        else if (opc[5:3] == IDX_F || opc[2:0] == IDX_F) dcd.kind = K_MEM;  // R5
        else                                             dcd.kind = K_MOVE; // R3
      end
      2'b00: begin
        if (opc[2:0] == 3'b110)
          dcd.kind = (opc[5:3] == IDX_F) ? K_MEM : K_IMM8;                  // R6
        else if (opc[3:0] == 4'h1)
          dcd.kind = K_IMM16;                                               // R7
        else if (opc[2:0] == 3'b011)
          dcd.kind = K_STEP;                                                // R8
        else if (opc == 8'h08)
          dcd.kind = K_SWAP_AF;                                             // R10
        else if (opc[2:0] == 3'b010)
          dcd.kind = K_MEM;                                                 // R5
        else
          dcd.kind = K_BAD;                                                 // R13
      end
      default: begin
        case (opc)
          8'hD9:   dcd.kind = K_SWAP_ALL;  // R11
          8'hEB:   dcd.kind = K_SWAP_DEHL; // R12
          8'hF9:   dcd.kind = K_SPHL;      // R9
          default: dcd.kind = K_BAD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/regfile_step16.sv
`timescale 1ns/1ps
module regfile_step16 #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         down,
  output logic [W-1:0] res
);
  // modulo 2^W by plain truncation, no flag side effects (R8)
  assign res = down ? (val - W'(1)) : (val + W'(1));
endmodule

// File: rtl/regfile_banks.sv
`timescale 1ns/1ps
module regfile_banks
  import regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  dec_t                     dcd,
  input  logic [2*BYTE_W-1:0]      imm,
  input  logic [2*BYTE_W-1:0]      step_res,
  output logic [2*BYTE_W-1:0]      step_src,
  output logic [NREG*BYTE_W-1:0]   main_flat,
  output logic [NREG*BYTE_W-1:0]   shadow_flat,
  output logic [2*BYTE_W-1:0]      sp_q
);
  localparam int PW = 2 * BYTE_W;

  logic [BYTE_W-1:0] main_q [NREG];
  logic [BYTE_W-1:0] shad_q [NREG];
  logic [BYTE_W-1:0] main_d [NREG];
  logic [BYTE_W-1:0] shad_d [NREG];
  logic [PW-1:0]     sp_d;

  logic [CODE_W-1:0] hi_idx, lo_idx;
  assign hi_idx = {dcd.pair, 1'b0};
  assign lo_idx = {dcd.pair, 1'b1};

  always_comb begin
    if (dcd.pair == PAIR_SP) step_src = sp_q;
    else                     step_src = {main_q[hi_idx], main_q[lo_idx]};
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      main_d[i] = main_q[i];
      shad_d[i] = shad_q[i];
    end
    sp_d = sp_q;
    case (dcd.kind)
      K_MOVE: main_d[dcd.dst] = main_q[dcd.src];
      K_IMM8: main_d[dcd.dst] = imm[BYTE_W-1:0];
      K_IMM16: begin
        if (dcd.pair == PAIR_SP) sp_d = imm;
        else begin
          main_d[hi_idx] = imm[PW-1:BYTE_W];
          main_d[lo_idx] = imm[BYTE_W-1:0];
        end
      end
      K_STEP: begin
        if (dcd.pair == PAIR_SP) sp_d = step_res;
        else begin
          main_d[hi_idx] = step_res[PW-1:BYTE_W];
          main_d[lo_idx] = step_res[BYTE_W-1:0];
        end
      end
      K_SPHL: sp_d = {main_q[IDX_H], main_q[IDX_L]};
      K_SWAP_AF: begin
        for (int i = int'(IDX_F); i < NREG; i++) begin
          main_d[i] = shad_q[i];
          shad_d[i] = main_q[i];
        end
      end
      K_SWAP_ALL: begin
        for (int i = 0; i < int'(IDX_F); i++) begin
          main_d[i] = shad_q[i];
          shad_d[i] = main_q[i];
        end
      end
      K_SWAP_DEHL: begin
        main_d[IDX_D] = main_q[IDX_H];
        main_d[IDX_E] = main_q[IDX_L];
        main_d[IDX_H] = main_q[IDX_D];
        main_d[IDX_L] = main_q[IDX_E];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        main_q[i] <= '0;
        shad_q[i] <= '0;
      end
      sp_q <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++) begin
        main_q[i] <= main_d[i];
        shad_q[i] <= shad_d[i];
      end
      sp_q <= sp_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign main_flat[g*BYTE_W +: BYTE_W]   = main_q[g];
    assign shadow_flat[g*BYTE_W +: BYTE_W] = shad_q[g];
  end
endmodule

// File: rtl/regfile_core.sv
`timescale 1ns/1ps
module regfile_core
  import regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [OPC_W-1:0]      op_code,
  input  logic [2*BYTE_W-1:0]   op_imm,
  input  logic [CODE_W-1:0]     rd_idx,
  output logic [BYTE_W-1:0]     rd_byte,
  output logic [2*BYTE_W-1:0]   sp_o,
  output logic                  halt_o,
  output logic                  mem_op_o,
  output logic                  bad_op_o
);
  localparam int PW = 2 * BYTE_W;

  dec_t                     dcd;
  logic                     accept;
  logic [PW-1:0]            step_src, step_res;
  logic [NREG*BYTE_W-1:0]   main_flat, shadow_flat;
  logic [PW-1:0]            sp_q;

  assign op_ready = ~rst;                 // R2: no back-pressure outside reset
  assign accept   = op_valid & op_ready;

  regfile_dec u_dec (.opc(op_code), .dcd(dcd));

  regfile_step16 #(.W(PW)) u_step (.val(step_src), .down(dcd.down), .res(step_res));

  regfile_banks #(.BYTE_W(BYTE_W)) u_banks (
    .clk        (clk),
    .rst        (rst),
    .we         (accept),
    .dcd        (dcd),
    .imm        (op_imm),
    .step_res   (step_res),
    .step_src   (step_src),
    .main_flat  (main_flat),
    .shadow_flat(shadow_flat),
    .sp_q       (sp_q)
  );

  assign rd_byte = main_flat[rd_idx*BYTE_W +: BYTE_W];
  assign sp_o    = sp_q;

  // R14: status pulses registered on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_o   <= 1'b0;
      mem_op_o <= 1'b0;
      bad_op_o <= 1'b0;
    end else begin
      halt_o   <= accept && (dcd.kind == K_HALT);
      mem_op_o <= accept && (dcd.kind == K_MEM);
      bad_op_o <= accept && (dcd.kind == K_BAD);
    end
  end
endmodule

// File: rtl/regfile_core_chk.sv
`timescale 1ns/1ps
module regfile_core_chk #(
  parameter int BYTE_W = 8,
  parameter int NR     = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  op_valid,
  input logic                  op_ready,
  input logic [7:0]            op_code,
  input logic                  halt_o,
  input logic                  mem_op_o,
  input logic                  bad_op_o,
  input logic [NR*BYTE_W-1:0]  main_flat,
  input logic [NR*BYTE_W-1:0]  shadow_flat,
  input logic [2*BYTE_W-1:0]   sp_q
);
  localparam int GW = 6 * BYTE_W;
  logic acc;
  assign acc = op_valid && op_ready;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (main_flat == '0 && shadow_flat == '0 && sp_q == '0 &&
             !halt_o && !mem_op_o && !bad_op_o));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(main_flat) && $stable(shadow_flat) && $stable(sp_q)));

  a_r4_halt_holds: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> ($stable(main_flat) && $stable(shadow_flat) && $stable(sp_q)));

  a_r5_mem_holds: assert property (@(posedge clk) disable iff (rst)
    mem_op_o |-> ($stable(main_flat) && $stable(shadow_flat) && $stable(sp_q)));

  a_r13_bad_holds: assert property (@(posedge clk) disable iff (rst)
    bad_op_o |-> ($stable(main_flat) && $stable(shadow_flat) && $stable(sp_q)));

  a_r14_one_status: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_o, mem_op_o, bad_op_o}));

  a_r8_sp_up: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 8'h33) |=> (sp_q == (2*BYTE_W)'($past(sp_q) + 1'b1)));

  a_r10_af_swap: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 8'h08) |=>
      (main_flat[NR*BYTE_W-1:GW] == $past(shadow_flat[NR*BYTE_W-1:GW]) &&
       shadow_flat[NR*BYTE_W-1:GW] == $past(main_flat[NR*BYTE_W-1:GW]) &&
       $stable(main_flat[GW-1:0]) && $stable(shadow_flat[GW-1:0])));

  a_r11_bank_swap: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 8'hD9) |=>
      (main_flat[GW-1:0] == $past(shadow_flat[GW-1:0]) &&
       shadow_flat[GW-1:0] == $past(main_flat[GW-1:0]) &&
       $stable(main_flat[NR*BYTE_W-1:GW]) && $stable(shadow_flat[NR*BYTE_W-1:GW])));

  a_r12_shadow_kept: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 8'hEB) |=> ($stable(shadow_flat) && $stable(sp_q)));
endmodule

bind regfile_core regfile_core_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_code    (op_code),
  .halt_o     (halt_o),
  .mem_op_o   (mem_op_o),
  .bad_op_o   (bad_op_o),
  .main_flat  (main_flat),
  .shadow_flat(shadow_flat),
  .sp_q       (sp_q)
);

// File: tb/regfile_core_tb.sv
`timescale 1ns/1ps
module regfile_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = 8'h00;
  logic [15:0] op_imm = 16'h0000;
  logic [2:0]  rd_idx = 3'd0;
  logic [7:0]  rd_byte;
  logic [15:0] sp_o;
  logic        halt_o, mem_op_o, bad_op_o;

  always #4 clk = ~clk;  // 125 MHz

  regfile_core u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_imm(op_imm), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .sp_o(sp_o), .halt_o(halt_o), .mem_op_o(mem_op_o), .bad_op_o(bad_op_o)
  );

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0]  mm [8];
  logic [7:0]  ms [8];
  logic [15:0] msp;
  logic [2:0]  exp_st;  // {halt, mem, bad}
  string       cur_req;

  task automatic model(input logic [7:0] op, input logic [15:0] imm);
    logic [15:0] v;
    logic [7:0]  t;
    int p;
    exp_st = 3'b000;
    p = int'(op[5:4]);
    if (op[7:6] == 2'b01) begin
      if (op == 8'h76) begin exp_st = 3'b100; cur_req = "R4"; end
      else if (op[5:3] == 3'd6 || op[2:0] == 3'd6) begin exp_st = 3'b010; cur_req = "R5"; end
      else begin mm[op[5:3]] = mm[op[2:0]]; cur_req = "R3"; end
    end else if (op[7:6] == 2'b00 && op[2:0] == 3'b110) begin
      if (op[5:3] == 3'd6) begin exp_st = 3'b010; cur_req = "R5"; end
      else begin mm[op[5:3]] = imm[7:0]; cur_req = "R6"; end
    end else if (op[7:6] == 2'b00 && op[3:0] == 4'h1) begin
      cur_req = "R7";
      if (p == 3) msp = imm;
      else begin mm[2*p] = imm[15:8]; mm[2*p+1] = imm[7:0]; end
    end else if (op[7:6] == 2'b00 && (op[3:0] == 4'h3 || op[3:0] == 4'hB)) begin
      cur_req = "R8";
      v = (p == 3) ? msp : {mm[2*p], mm[2*p+1]};
      v = op[3] ? v - 16'd1 : v + 16'd1;
      if (p == 3) msp = v;
      else begin mm[2*p] = v[15:8]; mm[2*p+1] = v[7:0]; end
    end else if (op == 8'h08) begin
      cur_req = "R10";
      for (int i = 6; i < 8; i++) begin t = mm[i]; mm[i] = ms[i]; ms[i] = t; end
    end else if (op[7:6] == 2'b00 && (op[3:0] == 4'h2 || op[3:0] == 4'hA)) begin
      exp_st = 3'b010; cur_req = "R5";
    end else if (op == 8'hD9) begin
      cur_req = "R11";
      for (int i = 0; i < 6; i++) begin t = mm[i]; mm[i] = ms[i]; ms[i] = t; end
    end else if (op == 8'hEB) begin
      cur_req = "R12";
      t = mm[2]; mm[2] = mm[4]; mm[4] = t;
      t = mm[3]; mm[3] = mm[5]; mm[5] = t;
    end else if (op == 8'hF9) begin
      cur_req = "R9"; msp = {mm[4], mm[5]};
    end else begin
      exp_st = 3'b001; cur_req = "R13";
    end
  endtask

  task automatic check_state(input string req, input logic [7:0] op);
    checks++;
    if ({halt_o, mem_op_o, bad_op_o} !== exp_st) begin
      bad++;
      $display("FAIL %s op=%02h status got=%b exp=%b", req, op,
               {halt_o, mem_op_o, bad_op_o}, exp_st);
    end
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.2;
      checks++;
      if (rd_byte !== mm[i]) begin
        bad++;
        $display("FAIL %s op=%02h reg%0d got=%02h exp=%02h", req, op, i, rd_byte, mm[i]);
      end
    end
    checks++;
    if (sp_o !== msp) begin
      bad++;
      $display("FAIL %s op=%02h sp got=%04h exp=%04h", req, op, sp_o, msp);
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [15:0] imm);
    @(negedge clk);
    checks++;  // R14: previous pulse has dropped
    if ({halt_o, mem_op_o, bad_op_o} !== 3'b000) begin
      bad++;
      $display("FAIL R14 pulse still high got=%b exp=000", {halt_o, mem_op_o, bad_op_o});
    end
    op_valid = 1'b1; op_code = op; op_imm = imm;
    model(op, imm);
    @(negedge clk);
    op_valid = 1'b0;
    check_state(cur_req, op);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mm[i] = 8'h00; ms[i] = 8'h00; end
    msp = 16'h0000; exp_st = 3'b000;
    // R1: reset with a load pending must not load, and ready stays low
    op_valid = 1'b1; op_code = 8'h3E; op_imm = 16'h00AA;
    repeat (3) @(negedge clk);
    checks++;
    if (op_ready !== 1'b0) begin
      bad++; $display("FAIL R1 ready in reset got=%b exp=0", op_ready);
    end
    op_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_state("R1", 8'h00);
    checks++;
    if (op_ready !== 1'b1) begin
      bad++; $display("FAIL R2 ready after reset got=%b exp=1", op_ready);
    end

    // R6 / R7 preload with distinct values
    do_op(8'h06, 16'h0011); do_op(8'h0E, 16'h0022); do_op(8'h16, 16'h0033);
    do_op(8'h1E, 16'h0044); do_op(8'h26, 16'h0055); do_op(8'h2E, 16'h0066);
    do_op(8'h3E, 16'h0077); do_op(8'h31, 16'hBEEF);
    do_op(8'hD9, 16'h0);    // R11 park values in shadow
    do_op(8'h01, 16'h1234); do_op(8'h11, 16'h5678); do_op(8'h21, 16'h9ABC);
    do_op(8'h08, 16'h0);    // R10
    do_op(8'h3E, 16'h00C3);

    // R8 wrap corners
    do_op(8'h31, 16'hFFFF); do_op(8'h33, 16'h0);  // SP -> 0000
    do_op(8'h3B, 16'h0);                          // SP -> FFFF
    do_op(8'h01, 16'h0000); do_op(8'h0B, 16'h0);  // BC -> FFFF
    do_op(8'h03, 16'h0);                          // BC -> 0000
    do_op(8'h21, 16'h00FF); do_op(8'h23, 16'h0);  // carry into H
    do_op(8'hF9, 16'h0);                          // R9

    // R2: valid low with live-looking inputs
    @(negedge clk);
    op_valid = 1'b0; op_code = 8'h21; op_imm = 16'hDEAD;
    exp_st = 3'b000;
    repeat (3) @(negedge clk);
    check_state("R2", 8'h21);

    // exhaustive opcode sweep, two operand patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int o = 0; o < 256; o++) begin
        logic [7:0] ob;
        ob = 8'(o);
        do_op(ob, {ob ^ 8'hA5 ^ 8'(pass * 37), ob + 8'h3C + 8'(pass * 91)});
      end
    end
    // shadow contents brought into view
    do_op(8'h08, 16'h0); do_op(8'hD9, 16'h0); do_op(8'hEB, 16'h0);
    do_op(8'hD9, 16'h0); do_op(8'h08, 16'h0);

    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule